// File: doc/BRIEF.md
# External Interrupt Request Combiner

This block folds one dedicated active-low interrupt pin and up to eight general-purpose port pins into a single interrupt request for a small CPU core. A compile-time bit mask decides which port pins may ever act as interrupt sources. At run time, a port pin that the direction register sets as an output is removed from the set. The dedicated pin and every remaining port source are ANDed into one combined active-low level. A falling edge on that level sets a pending latch, and the CPU's acknowledge of interrupt entry clears it.

A compile-time mode selects one of two behaviours. In edge mode only the pending latch raises the request. In level mode the request is also raised for as long as the combined level stays low. The request is gated by the CPU's interrupt-mask input. The latch still records edges while the mask is set, so an edge that arrives while masked is serviced later. The combined level is also given out on its own, for the CPU's branch-if-pin-high and branch-if-pin-low instructions. The two vector byte addresses, 0x3FFA and 0x3FFB, are driven as constants.

Top module: `ext_irq_combiner`

## Requirements
- R1: A port pin whose bit in the compile-time enable mask is 0 never affects the combined level or the request.
- R2: An enabled port pin whose direction bit is 1 (output) is ignored. Clearing the direction bit to 0 makes it a source again.
- R3: The combined level is low when the dedicated pin or any active port source is low. A high-to-low change of the combined level sets the pending latch.
- R4: While any other source keeps the combined level low, a falling edge on one more source sets no new pending state.
- R5: In edge mode (LEVEL_MODE=0), the request is high only while the pending latch is set.
- R6: In level mode (LEVEL_MODE=1), the request is also high while the combined level is low, even with the latch clear.
- R7: A one-cycle acknowledge pulse clears the pending latch on the next clock edge.
- R8: If a falling edge is detected in the same cycle as the acknowledge, the latch stays set.
- R9: The irq_level output is the synchronised combined level of all active sources, not the bare dedicated pin.
- R10: While cpu_imask is 1 the request is 0. An edge seen while masked still sets the latch, and the request rises once the mask clears.
- R11: vec_addr_hi reads 0x3FFA and vec_addr_lo reads 0x3FFB.
- R12: Every pin passes two synchroniser flops. A pin driven low before clock edge 1 sets the request after clock edge 3 in edge mode, and after clock edge 2 in level mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin_n | input | 1 | Dedicated active-low interrupt pin |
| port_pin | input | 8 | Port pin levels |
| port_dir | input | 8 | Direction bits, 1 = output (not a source) |
| cpu_imask | input | 1 | CPU interrupt mask, 1 = masked |
| int_ack | input | 1 | Pulse on interrupt entry, clears pending |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_level | output | 1 | Combined active-low level for branch-on-pin instructions |
| vec_addr_hi | output | 14 | Address of the vector high byte |
| vec_addr_lo | output | 14 | Address of the vector low byte |

## Verification
The bench builds two copies of the block from the same stimulus. Both use enable mask 8'hA5, so bits 1, 3, 4 and 6 are masked off; one copy uses LEVEL_MODE=0 and the other LEVEL_MODE=1. Running them side by side shows, in every vector, where the level path and the latch-only path give different requests, for example after an acknowledge while a source is still held low. The enabled/disabled split of the mask lets the same port patterns test both the mask exclusion and the direction-bit exclusion.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Register state of the edge detector and pending latch
    typedef struct packed {
        logic prev_lvl;   // combined level seen last cycle
        logic pend;       // pending request latch
    } edge_state_t;

    localparam edge_state_t EDGE_RST = '{prev_lvl: 1'b1, pend: 1'b0};

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int WIDTH  = 9,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    // Idle level of every pin is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '1;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/irqc_merge.sv
module irqc_merge #(
    parameter int               PORT_W = 8,
    parameter logic [PORT_W-1:0] SRC_EN = '1
) (
    input  logic              irq_s,
    input  logic [PORT_W-1:0] port_s,
    input  logic [PORT_W-1:0] port_dir,
    output logic              merged_lvl
);

    logic [PORT_W-1:0] term_hi;

    // A disabled or output-configured pin reads as high
    for (genvar g = 0; g < PORT_W; g++) begin : g_term
        if (SRC_EN[g]) begin : g_src
            assign term_hi[g] = port_s[g] | port_dir[g];
        end else begin : g_off
            assign term_hi[g] = 1'b1;
        end
    end

    assign merged_lvl = irq_s & (&term_hi);

endmodule

// File: rtl/irqc_latch.sv
module irqc_latch
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic merged_lvl,
    input  logic ack,
    output logic fall,
    output logic pend
);

    edge_state_t st_d, st_q;

    always_comb begin
        fall           = st_q.prev_lvl & ~merged_lvl;
        st_d.prev_lvl  = merged_lvl;
        // New edge wins over acknowledge
        st_d.pend      = fall | (st_q.pend & ~ack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= EDGE_RST;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;

endmodule

// File: rtl/ext_irq_combiner.sv
module ext_irq_combiner #(
    parameter int                PORT_W      = 8,
    parameter logic [PORT_W-1:0] PORT_IRQ_EN = '1,
    parameter bit                LEVEL_MODE  = 1'b0,
    parameter int                SYNC_STAGES = 2,
    parameter int                ADDR_W      = 14,
    parameter logic [ADDR_W-1:0] VEC_HI_ADDR = 14'h3FFA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_pin_n,
    input  logic [PORT_W-1:0] port_pin,
    input  logic [PORT_W-1:0] port_dir,
    input  logic              cpu_imask,
    input  logic              int_ack,
    output logic              irq_req,
    output logic              irq_level,
    output logic [ADDR_W-1:0] vec_addr_hi,
    output logic [ADDR_W-1:0] vec_addr_lo
);

    localparam int                SYNC_W      = PORT_W + 1;
    localparam logic [ADDR_W-1:0] VEC_LO_ADDR = VEC_HI_ADDR + 1'b1;

    logic [SYNC_W-1:0] pins_s;
    logic              merged_lvl;
    logic              fall_det;
    logic              pend_q;
    logic              lvl_term;

    irqc_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({irq_pin_n, port_pin}),
        .dout (pins_s)
    );

    irqc_merge #(.PORT_W(PORT_W), .SRC_EN(PORT_IRQ_EN)) u_merge (
        .irq_s     (pins_s[SYNC_W-1]),
        .port_s    (pins_s[PORT_W-1:0]),
        .port_dir  (port_dir),
        .merged_lvl(merged_lvl)
    );

    irqc_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .merged_lvl(merged_lvl),
        .ack       (int_ack),
        .fall      (fall_det),
        .pend      (pend_q)
    );

    if (LEVEL_MODE) begin : g_level
        assign lvl_term = ~merged_lvl;
    end else begin : g_edge
        assign lvl_term = 1'b0;
    end

    assign irq_req     = ~cpu_imask & (pend_q | lvl_term);
    assign irq_level   = merged_lvl;
    assign vec_addr_hi = VEC_HI_ADDR;
    assign vec_addr_lo = VEC_LO_ADDR;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter bit LEVEL_MODE = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic int_ack,
    input logic cpu_imask,
    input logic irq_req,
    input logic irq_level,
    input logic pend,
    input logic fall
);

    // R3: a detected edge follows a high combined level
    a_r3_fall_from_high: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> (!irq_level && $past(irq_level)));

    // R3: the latch holds without an edge or an acknowledge
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !int_ack) |=> $stable(pend));

    // R7
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !fall) |=> !pend);

    // R8
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> pend);

    // R10
    a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_imask |-> !irq_req);

    if (LEVEL_MODE) begin : g_lvl
        // R6
        a_r6_level_path: assert property (@(posedge clk) disable iff (!rst_n)
            (!cpu_imask && !irq_level) |-> irq_req);
    end else begin : g_edge
        // R5
        a_r5_latch_only: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req |-> pend);
    end

endmodule

bind ext_irq_combiner irqc_checker #(.LEVEL_MODE(LEVEL_MODE)) u_irqc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .int_ack  (int_ack),
    .cpu_imask(cpu_imask),
    .irq_req  (irq_req),
    .irq_level(irq_level),
    .pend     (pend_q),
    .fall     (fall_det)
);

// File: tb/ext_irq_combiner_bench.sv
module ext_irq_combiner_bench;

    localparam logic [7:0] EN = 8'hA5;
    localparam int NV = 19;

    // {irq_n, port[7:0], dir[7:0], imask, ack, exp_req_edge, exp_req_lvl, exp_level}
    localparam logic [21:0] VEC [NV] = '{
        {1'b1, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // 0  idle
        {1'b0, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // 1  R3 pin falls
        {1'b1, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // 2  R7 ack clears
        {1'b1, 8'hFE, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // 3  R3 port bit0 falls
        {1'b1, 8'hFE, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // 4  R5/R6 ack while low
        {1'b1, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // 5  release
        {1'b1, 8'hFD, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // 6  R1 bit1 masked off
        {1'b1, 8'hFE, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // 7  R2 bit0 output
        {1'b1, 8'hFE, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // 8  R2 back to input
        {1'b1, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // 9  clear
        {1'b0, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // 10 pin falls
        {1'b0, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // 11 ack, pin held
        {1'b0, 8'hFB, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // 12 R4 bit2 falls under pin
        {1'b1, 8'hFB, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // 13 R9 pin high, bit2 low
        {1'b1, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // 14 release
        {1'b0, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // 15 R10 edge while masked
        {1'b1, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // 16 R10 still masked
        {1'b1, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // 17 R10 unmask, pending
        {1'b1, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}  // 18 clear
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_pin_n = 1'b1;
    logic [7:0] port_pin = 8'hFF;
    logic [7:0] port_dir = 8'h00;
    logic       cpu_imask = 1'b0;
    logic       int_ack = 1'b0;
    logic       req_e, lvl_e, req_l, lvl_l;
    logic [13:0] vhi_e, vlo_e, vhi_l, vlo_l;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ext_irq_combiner #(.PORT_IRQ_EN(EN), .LEVEL_MODE(1'b0)) u_ext_irq_combiner (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .port_pin(port_pin),
        .port_dir(port_dir), .cpu_imask(cpu_imask), .int_ack(int_ack),
        .irq_req(req_e), .irq_level(lvl_e), .vec_addr_hi(vhi_e), .vec_addr_lo(vlo_e)
    );

    ext_irq_combiner #(.PORT_IRQ_EN(EN), .LEVEL_MODE(1'b1)) u_ext_irq_combiner_lvl (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .port_pin(port_pin),
        .port_dir(port_dir), .cpu_imask(cpu_imask), .int_ack(int_ack),
        .irq_req(req_l), .irq_level(lvl_l), .vec_addr_hi(vhi_l), .vec_addr_lo(vlo_l)
    );

    task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", what, got, exp);
        end
    endtask

    task automatic idle_all();
        irq_pin_n = 1'b1; port_pin = 8'hFF; port_dir = 8'h00;
        cpu_imask = 1'b0; int_ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // Reset state
        check("reset req edge", {31'd0, req_e}, 32'd0);
        check("reset req lvl", {31'd0, req_l}, 32'd0);
        check("reset level R9", {31'd0, lvl_e}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 vec hi", {18'd0, vhi_e}, 32'h3FFA);
        check("R11 vec lo", {18'd0, vlo_e}, 32'h3FFB);
        check("R11 vec lo lvl", {18'd0, vlo_l}, 32'h3FFB);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [21:0] v;
            v = VEC[i];
            irq_pin_n = v[21];
            port_pin  = v[20:13];
            port_dir  = v[12:5];
            cpu_imask = v[4];
            repeat (4) @(negedge clk);
            if (v[3]) begin
                int_ack = 1'b1;
                @(negedge clk);
                int_ack = 1'b0;
            end
            check($sformatf("vec %0d req edge R3/R5/R7", i), {31'd0, req_e}, {31'd0, v[2]});
            check($sformatf("vec %0d req lvl R6", i), {31'd0, req_l}, {31'd0, v[1]});
            check($sformatf("vec %0d level R9/R1/R2/R4", i), {31'd0, lvl_e}, {31'd0, v[0]});
        end

        // R12: latency through the synchroniser
        idle_all();
        repeat (4) @(negedge clk);
        irq_pin_n = 1'b0;
        @(negedge clk);
        check("R12 edge after 1", {31'd0, req_e}, 32'd0);
        check("R12 lvl after 1", {31'd0, req_l}, 32'd0);
        @(negedge clk);
        check("R12 edge after 2", {31'd0, req_e}, 32'd0);
        check("R12 lvl after 2", {31'd0, req_l}, 32'd1);
        @(negedge clk);
        check("R12 edge after 3", {31'd0, req_e}, 32'd1);
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
        idle_all();
        repeat (4) @(negedge clk);
        check("R7 cleared before R8", {31'd0, req_e}, 32'd0);

        // R8: acknowledge in the same cycle as a new edge
        irq_pin_n = 1'b0;
        @(negedge clk);
        @(negedge clk);      // edge now visible to the latch logic
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
        check("R8 set beats ack", {31'd0, req_e}, 32'd1);
        repeat (2) @(negedge clk);
        check("R8 still pending", {31'd0, req_e}, 32'd1);

        // Reset while pending
        rst_n = 1'b0;
        @(negedge clk);
        check("reset clears pending", {31'd0, req_e}, 32'd0);
        check("reset level high R9", {31'd0, lvl_l}, 32'd1);
        idle_all();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("post-reset idle", {31'd0, req_l}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule